// File: doc/BRIEF.md
# Free-Running Timer with Output Compare

A 16-bit counter advances by one on every clock cycle that carries a prescaled tick enable. It never stops, never reloads and cannot be written. Several output-compare channels watch the counter. Each channel owns a 16-bit compare register, a status flag and an enable bit. When the counter reaches a channel's compare value, that channel's flag is set. The channel then raises its interrupt request if its enable bit is set. When the counter rolls over from all ones to zero, a separate overflow flag is set, and it has its own enable and request.

Software drives the block through a small register bus. It reads the counter. It writes the compare registers. It sets the enable bits in a mask register. It clears flags by writing ones to them in the flag register. A periodic event is kept going by adding a fixed offset to the compare register after every match. If a compare value is written after the counter has already gone past it, the match is lost until the counter has wrapped all the way round. The block does not recover that event.

Top module: `tmr_oc_top`

## Requirements
- R1: After reset the counter reads 0, the flag and mask registers read 0, and every compare register reads FFFFh.
- R2: The counter increments by one, modulo 2^16, at each clock edge where `tick` is 1, and holds its value when `tick` is 0.
- R3: At the tick that takes the counter from FFFFh to 0000h, the overflow flag (bit 0 of the flag register) is set. It becomes visible in the same cycle as the counter value 0.
- R4: Compare channel k (k = 1..N) owns flag and mask bit 8-k, so channel 1 is bit 7 and channel 3 is bit 5. Its flag is set at the tick that makes the counter equal to its compare register, and it is visible together with that counter value.
- R5: A match is evaluated only on tick cycles. While the counter rests on a matching value without ticks, a flag that software has cleared stays clear.
- R6: `cmp_irq[k-1]` is 1 exactly when channel k's flag and mask bit are both 1. `ovf_irq` is 1 exactly when the overflow flag and mask bit 0 are both 1.
- R7: Writing the flag register clears every flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R8: When a flag is set by a match and cleared by a write in the same cycle, it ends up set.
- R9: A compare value written below the current count produces no flag until the counter has wrapped and then reaches that value.
- R10: Writes to the counter address have no effect on the count.
- R11: Address 0 is the counter, 1 the flag register, 2 the mask register, and 4+k-1 channel k's compare register. Unused flag and mask bits read 0 and cannot be set.
- R12: A compare register rewritten to the current count plus d (with ticks halted during the write) sets its flag after exactly d further ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Prescaled count enable |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data of the addressed register (combinational) |
| cmp_irq | output | N_CMP | Per-channel compare interrupt requests |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
A flag can be set by a counter match and cleared by a software write in the same cycle. The bench causes this by loading a compare register with the next count value while ticks are halted. It then issues the write-one clear on the very cycle that carries the tick. The result is judged against a behavioural model that applies the clear before the set, and the flag register must read the bit as set afterwards. The same model is compared with the request outputs and the read data on every clock, across all other phases as well.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared constants of the output-compare timer: register addresses and
// bit placement inside the 8-bit flag and mask registers.
// Assumes at most 7 compare channels (bits 7 down to 1); bit 0 is overflow.
package tmr_pkg;
    localparam int unsigned REG_BITS  = 8;
    localparam int unsigned OVF_BIT   = 0;
    localparam int unsigned ADR_CNT   = 0;
    localparam int unsigned ADR_FLG   = 1;
    localparam int unsigned ADR_MSK   = 2;
    localparam int unsigned ADR_CMP0  = 4;

    // Bit of channel index k (0-based) in the flag and mask registers.
    function automatic int unsigned chan_bit(int unsigned k);
        return REG_BITS - 1 - k;
    endfunction

    // Bits of the flag/mask registers that exist for n channels.
    function automatic logic [REG_BITS-1:0] valid_bits(int unsigned n);
        logic [REG_BITS-1:0] v;
        v = '0;
        v[OVF_BIT] = 1'b1;
        for (int unsigned k = 0; k < n; k++) v[chan_bit(k)] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
// Free-running up counter. It advances on cycles with tick high, presents
// the next count for the compare logic, and reports a wrap from all ones.
// Assumes tick is a single-cycle enable synchronous to clk.
module tmr_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt,
    output logic         wrap
);
    assign cnt_nxt = cnt_q + W'(1);
    assign wrap    = tick && (cnt_q == '1);

    // Count register: advance on tick only.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_nxt;
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == $past(cnt_q) + W'(1)));
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_cmp_chan.sv
`timescale 1ns/1ps
// One output-compare channel: holds its compare value and a sticky flag.
// The flag is set on a tick whose new count equals the compare value and
// is cleared by a write-one strobe; a simultaneous set takes precedence.
// Assumes cnt_nxt is the value the counter takes on this tick.
module tmr_cmp_chan #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cnt_nxt,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         flag_clr,
    output logic [W-1:0] cmp_q,
    output logic         flag_q
);
    logic hit;
    assign hit = tick && (cnt_nxt == cmp_q);

    // Compare register: loaded by the bus, all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '1;
        else if (cmp_we) cmp_q <= cmp_wdata;
    end

    // Sticky flag: match sets, write-one clears, set dominates.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= hit | (flag_q & ~flag_clr);
    end

    p_match_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_nxt == cmp_q) |=> flag_q);
    p_quiet_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !flag_q) |=> !flag_q);
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(tick && cnt_nxt == cmp_q)) |=> !flag_q);
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && tick && cnt_nxt == cmp_q) |=> flag_q);
endmodule

// File: rtl/tmr_oc_top.sv
`timescale 1ns/1ps
// Free-running timer with output-compare channels and an overflow flag.
// Register bus: counter (read only), flag register (write one to clear),
// mask register, one compare register per channel. Requests are the AND of
// flag and mask. Assumes CNT_W >= 8 and N_CMP <= 7.
module tmr_oc_top
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned N_CMP  = 4,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [N_CMP-1:0]  cmp_irq,
    output logic              ovf_irq
);
    localparam logic [REG_BITS-1:0] VALID = valid_bits(N_CMP);

    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    cnt_nxt;
    logic                wrap;
    logic [CNT_W-1:0]    cmp_q [N_CMP];
    logic [N_CMP-1:0]    cmp_flag;
    logic                ovf_flag_q;
    logic [REG_BITS-1:0] mask_q;
    logic [REG_BITS-1:0] flag_rd;
    logic                wr_flg;
    logic                wr_msk;

    assign wr_flg = bus_wr && (bus_addr == ADDR_W'(ADR_FLG));
    assign wr_msk = bus_wr && (bus_addr == ADDR_W'(ADR_MSK));

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .wrap    (wrap)
    );

    for (genvar k = 0; k < N_CMP; k++) begin : g_chan
        localparam int unsigned FB = chan_bit(k);
        logic cmp_we;
        assign cmp_we = bus_wr && (bus_addr == ADDR_W'(ADR_CMP0 + k));

        tmr_cmp_chan #(.W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .cnt_nxt   (cnt_nxt),
            .cmp_we    (cmp_we),
            .cmp_wdata (bus_wdata),
            .flag_clr  (wr_flg && bus_wdata[FB]),
            .cmp_q     (cmp_q[k]),
            .flag_q    (cmp_flag[k])
        );

        assign cmp_irq[k] = cmp_flag[k] & mask_q[FB];
    end

    // Overflow flag: wrap sets, write-one clears, set dominates.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_flag_q <= 1'b0;
        else        ovf_flag_q <= wrap | (ovf_flag_q & ~(wr_flg && bus_wdata[OVF_BIT]));
    end

    // Mask register: only bits that exist are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '0;
        else if (wr_msk) mask_q <= bus_wdata[REG_BITS-1:0] & VALID;
    end

    assign ovf_irq = ovf_flag_q & mask_q[OVF_BIT];

    // Assemble the flag register view.
    always_comb begin
        flag_rd          = '0;
        flag_rd[OVF_BIT] = ovf_flag_q;
        for (int unsigned k = 0; k < N_CMP; k++) flag_rd[chan_bit(k)] = cmp_flag[k];
    end

    // Read multiplexer for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADR_CNT)) bus_rdata = cnt_q;
        if (bus_addr == ADDR_W'(ADR_FLG)) bus_rdata[REG_BITS-1:0] = flag_rd;
        if (bus_addr == ADDR_W'(ADR_MSK)) bus_rdata[REG_BITS-1:0] = mask_q;
        for (int unsigned k = 0; k < N_CMP; k++)
            if (bus_addr == ADDR_W'(ADR_CMP0 + k)) bus_rdata = cmp_q[k];
    end

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == '1) |=> ovf_flag_q);
    p_cnt_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && bus_wr && bus_addr == ADDR_W'(ADR_CNT)) |=> $stable(cnt_q));
    p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & ~VALID) == '0);
endmodule

// File: tb/test_tmr_oc_top.sv
`timescale 1ns/1ps
module test_tmr_oc_top;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [NCH-1:0] cmp_irq;
    logic        ovf_irq;

    int n_vec = 0;
    int n_bad = 0;
    string phase_req = "R1";
    bit done = 0;

    // Behavioural reference state.
    int m_cnt;
    int m_cmp [NCH];
    int m_flag;
    int m_mask;

    always #10 clk = ~clk;

    tmr_oc_top i_tmr_oc_top (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_irq(cmp_irq), .ovf_irq(ovf_irq)
    );

    function automatic int model_rd(int a);
        if (a == 0) return m_cnt;
        if (a == 1) return m_flag;
        if (a == 2) return m_mask;
        if (a >= 4 && a < 4 + NCH) return m_cmp[a-4];
        return 0;
    endfunction

    // Reference model update at each edge from the stable inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_flag = 0; m_mask = 0;
            for (int k = 0; k < NCH; k++) m_cmp[k] = 'hFFFF;
        end else begin
            int nxt, setb, clrb;
            nxt = (m_cnt + 1) % 65536;
            setb = 0;
            if (tick) begin
                for (int k = 0; k < NCH; k++) if (nxt == m_cmp[k]) setb |= (1 << (7 - k));
                if (m_cnt == 'hFFFF) setb |= 1;
            end
            clrb = (bus_wr && bus_addr == 1) ? (bus_wdata & 'hFF) : 0;
            m_flag = (m_flag & ~clrb) | setb;
            if (tick) m_cnt = nxt;
            if (bus_wr && bus_addr == 2) m_mask = bus_wdata & 'hF1;
            for (int k = 0; k < NCH; k++) if (bus_wr && bus_addr == 4 + k) m_cmp[k] = bus_wdata;
        end
    end

    // Per-clock comparison of every output against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_irq;
            exp_irq = 0;
            for (int k = 0; k < NCH; k++)
                if (((m_flag & m_mask) >> (7 - k)) & 1) exp_irq |= (1 << k);
            n_vec++;
            if (bus_rdata !== 16'(model_rd(int'(bus_addr)))) begin
                n_bad++;
                $display("FAIL %s: rdata addr %0d got %h exp %h", phase_req, bus_addr, bus_rdata, 16'(model_rd(int'(bus_addr))));
            end
            n_vec++;
            if (cmp_irq !== NCH'(exp_irq) || ovf_irq !== ((m_flag & m_mask & 1) != 0)) begin
                n_bad++;
                $display("FAIL R6: irq got %b/%b exp %b/%b", cmp_irq, ovf_irq, NCH'(exp_irq), (m_flag & m_mask & 1) != 0);
            end
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic chk(string req, int got, int expv);
        n_vec++;
        if (got != expv) begin
            n_bad++;
            $display("FAIL %s: got %h exp %h", req, got, expv);
        end
    endtask

    // Read a register away from the edge and return its value.
    task automatic rd(int a, output int v);
        bus_wr = 0; bus_addr = 4'(a); #1; v = int'(bus_rdata);
    endtask

    task automatic wr(int a, int d);
        bus_addr = 4'(a); bus_wdata = 16'(d); bus_wr = 1; step(); bus_wr = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        int v, c, late;
        repeat (3) step();
        rst_n = 1;
        // R1 and R11: reset values at every address.
        rd(0, v); chk("R1 counter", v, 0);
        rd(1, v); chk("R1 flags", v, 0);
        rd(2, v); chk("R1 mask", v, 0);
        for (int k = 0; k < NCH; k++) begin rd(4 + k, v); chk("R1 compare", v, 'hFFFF); end
        // R11: reserved mask bits stay zero.
        phase_req = "R11";
        wr(2, 'hFFFF); rd(2, v); chk("R11 mask readback", v, 'hF1);
        wr(2, 0);
        // R10: counter write ignored.
        phase_req = "R10";
        wr(0, 'h1234); rd(0, v); chk("R10 counter unchanged", v, 0);
        // R2 and R4: irregular ticks toward compare values.
        phase_req = "R4";
        wr(4, 10); wr(5, 10); wr(6, 12); wr(2, 'hA0);
        for (int i = 0; i < 100 && m_cnt != 10; i++) begin
            tick = (i % 3 == 0); step();
        end
        tick = 0;
        rd(0, v); chk("R2 counter reached", v, 10);
        rd(1, v); chk("R4 both channels at 10", v & 'hC0, 'hC0);
        // R5: clear while resting on the match without ticks.
        phase_req = "R5";
        repeat (3) step();
        wr(1, 'h80);
        repeat (4) step();
        rd(1, v); chk("R5 flag stays clear", v & 'h80, 0);
        // R7: partial clear leaves others.
        phase_req = "R7";
        tick = 1; step(); step(); tick = 0;
        rd(1, v); chk("R4 channel 3 at bit 5", v & 'h20, 'h20);
        wr(1, 'h20); rd(1, v); chk("R7 only bit 5 cleared", v & 'hE0, 'h40);
        // R8: set and clear collide.
        phase_req = "R8";
        wr(7, (m_cnt + 1) % 65536);
        bus_addr = 1; bus_wdata = 'h10; bus_wr = 1; tick = 1; step();
        bus_wr = 0; tick = 0;
        rd(1, v); chk("R8 set wins", v & 'h10, 'h10);
        // R12: reschedule with an offset.
        phase_req = "R12";
        wr(1, 'hF1);
        wr(4, (m_cnt + 5) % 65536);
        tick = 1; repeat (4) step(); tick = 0;
        rd(1, v); chk("R12 not yet", v & 'h80, 0);
        tick = 1; step(); tick = 0;
        rd(1, v); chk("R12 after offset", v & 'h80, 'h80);
        // R9: late compare write, then full wrap (R3).
        phase_req = "R9";
        wr(1, 'hF1);
        c = m_cnt; late = (c + 65535) % 65536;
        wr(5, late); wr(2, 'h01);
        tick = 1; repeat (200) step(); tick = 0;
        rd(1, v); chk("R9 no late match", v & 'h40, 0);
        phase_req = "R3";
        tick = 1;
        for (int i = 0; i < 70000 && m_cnt != 0; i++) step();
        tick = 0;
        rd(1, v); chk("R3 overflow flag", v & 1, 1);
        chk("R6 overflow request", int'(ovf_irq), 1);
        phase_req = "R9";
        tick = 1;
        for (int i = 0; i < 70000 && m_cnt != late; i++) step();
        tick = 0;
        rd(1, v); chk("R9 match after wrap", v & 'h40, 'h40);
        step();
        finish_run();
    end
endmodule